// File: doc/BRIEF.md
# Super I/O Configuration Port Controller

This block is the configuration front end of a Super I/O device on an 8-bit I/O-port bus. Two port addresses are decoded: an index port, which selects a configuration register, and a data port, which reads or writes the selected register. The configuration space stays hidden until software writes a four-byte unlock key to the index port. While the device is locked, index-port writes go only to the key matcher. Data-port accesses have no effect, and every read returns all ones.

Once unlocked, indices below 0x30 reach a global area. This area holds the logical device selector, the 16-bit chip identifier and the revision nibble. Indices from 0x30 upward reach the bank of the selected logical device. Only the GPIO device (number 7) has a bank here. Its bank holds the 16-bit GPIO I/O base address, a set of per-group simple-I/O enable bytes and a set of per-group output-enable bytes. All of these drive straight out to the GPIO logic. Writing the exit command to the exit index locks the device again.

Reads are registered: the value appears on `bus_rdata` after the clock edge that sampled `bus_rd`, and it is held until the next read.

Top module: `svio_cfg_port`

## Requirements
- R1: After reset the device is locked (`cfg_open`=0), the logical device number is 0, `gpio_base` equals the reset base (0x0A00 by default), all enable outputs are 0 and `bus_rdata` is 0xFF.
- R2: Index-port (0x2E) writes of 0x87, 0x01, 0x55, 0x55 in order raise `cfg_open` in the cycle after the fourth write.
- R3: A locked index write that does not match the next key byte restarts matching; if that byte is 0x87 it counts as the first key byte.
- R4: While locked, data-port (0x2F) writes change nothing, and reads of either port return 0xFF.
- R5: While open, an index-port write stores the index, and an index-port read returns the stored index.
- R6: Global index 0x20 reads the identifier high byte (0x87 by default), 0x21 the low byte (0x28), and 0x22 reads 0x0 in its upper nibble with the revision (3) in its lower nibble; writes to these indices are ignored.
- R7: Global index 0x07 is the read/write logical device number; bank indices (0x30 and up) read 0xFF and ignore writes unless that number is 7.
- R8: In the GPIO bank, index 0x62 holds the base address high byte and 0x63 the low byte; `gpio_base` follows a write in the next cycle.
- R9: GPIO bank index 0xC0+g, for group g below the simple-group count (5), is a read/write simple-I/O enable byte driving `gpio_simple_en[8g+7:8g]`; 0xC5 through 0xC7 read 0xFF.
- R10: GPIO bank index 0xC8+g, for group g below the output-group count (8), is a read/write output-enable byte driving `gpio_oe[8g+7:8g]`.
- R11: While open, a data write of 0x02 while the index is 0x02 locks the device in the next cycle; any other value written there leaves it open.
- R12: Reads at any other bus address, and reads of unimplemented indices, return 0xFF in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | I/O port address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cfg_open | output | 1 | Configuration mode active |
| gpio_base | output | 16 | GPIO I/O base address |
| gpio_simple_en | output | 40 | Simple-I/O enable bytes, group g in bits 8g+7:8g |
| gpio_oe | output | 64 | Output-enable bytes, group g in bits 8g+7:8g |

## Verification
Every result of this block is due exactly one edge after its stimulus. A read's data appears after the edge that samples `bus_rd`. A register write reaches `gpio_base`, `gpio_simple_en` or `gpio_oe` after the edge of the write. `cfg_open` rises after the edge of the fourth key byte and falls after the edge of the exit write. The bench drives strobes on the falling edge and keeps them for one full cycle. It then samples on the next falling edge, half a cycle after the edge that updates the design. A behavioural reference model advances on the same rising edge, so the per-cycle comparison and the directed checks both look at the cycle in which each result is due.

// File: rtl/svio_pkg.sv
package svio_pkg;

   localparam int          KEY_LEN    = 4;
   localparam logic [7:0]  IDX_EXIT   = 8'h02;
   localparam logic [7:0]  IDX_LDN    = 8'h07;
   localparam logic [7:0]  IDX_ID_HI  = 8'h20;
   localparam logic [7:0]  IDX_ID_LO  = 8'h21;
   localparam logic [7:0]  IDX_REV    = 8'h22;
   localparam logic [7:0]  CMD_EXIT   = 8'h02;
   localparam logic [7:0]  BANK_FIRST = 8'h30;
   localparam logic [7:0]  RD_FLOAT   = 8'hFF;

   typedef logic [7:0] byte_t;

   function automatic byte_t key_byte(input int pos);
      case (pos)
         0:       return 8'h87;
         1:       return 8'h01;
         default: return 8'h55;
      endcase
   endfunction

endpackage

// File: rtl/svio_key_match.sv
module svio_key_match
   import svio_pkg::*;
#(
   parameter int LEN = KEY_LEN
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  kick,
   input  byte_t kbyte,
   input  logic  relock,
   output logic  open
);

   localparam int PW = (LEN > 1) ? $clog2(LEN) : 1;
   localparam int LAST = LEN - 1;

   logic [PW-1:0] pos_q;
   byte_t         want;

   assign want = key_byte(int'(pos_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q <= '0;
         open  <= 1'b0;
      end else if (relock) begin
         pos_q <= '0;
         open  <= 1'b0;
      end else if (kick && !open) begin
         if (kbyte == want) begin
            if (int'(pos_q) == LAST) begin
               pos_q <= '0;
               open  <= 1'b1;
            end else begin
               pos_q <= pos_q + 1'b1;
            end
         end else if (kbyte == key_byte(0)) begin
            pos_q <= PW'(1);
         end else begin
            pos_q <= '0;
         end
      end
   end

endmodule

// File: rtl/svio_global_regs.sv
module svio_global_regs
   import svio_pkg::*;
#(
   parameter logic [15:0] CHIP_ID  = 16'h8728,
   parameter logic [3:0]  CHIP_REV = 4'h3
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  open,
   input  logic  idx_wr,
   input  logic  dat_wr,
   input  byte_t wdata,
   output byte_t idx,
   output byte_t ldn,
   output logic  relock,
   output logic  in_global,
   output byte_t rd_val
);

   assign in_global = (idx < BANK_FIRST);
   assign relock    = open && dat_wr && (idx == IDX_EXIT) && (wdata == CMD_EXIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx <= '0;
         ldn <= '0;
      end else begin
         if (open && idx_wr)
            idx <= wdata;
         if (open && dat_wr && idx == IDX_LDN)
            ldn <= wdata;
      end
   end

   always_comb begin
      case (idx)
         IDX_LDN:   rd_val = ldn;
         IDX_ID_HI: rd_val = CHIP_ID[15:8];
         IDX_ID_LO: rd_val = CHIP_ID[7:0];
         IDX_REV:   rd_val = {4'h0, CHIP_REV};
         default:   rd_val = RD_FLOAT;
      endcase
   end

endmodule

// File: rtl/svio_gpio_bank.sv
module svio_gpio_bank
   import svio_pkg::*;
#(
   parameter int          NUM_SIMPLE  = 5,
   parameter int          NUM_OE      = 8,
   parameter logic [7:0]  SIMPLE_BASE = 8'hC0,
   parameter logic [7:0]  OE_BASE     = 8'hC8,
   parameter logic [7:0]  BASE_IDX    = 8'h62,
   parameter logic [15:0] BASE_RST    = 16'h0A00,
   localparam int         SIMPLE_W    = (NUM_SIMPLE > 0) ? NUM_SIMPLE * 8 : 8,
   localparam int         OE_W        = NUM_OE * 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  byte_t               idx,
   input  byte_t               wdata,
   output logic [15:0]         base,
   output logic [SIMPLE_W-1:0] simple_en,
   output logic [OE_W-1:0]     oe,
   output byte_t               rd_val
);

   localparam logic [7:0] BASE_LO_IDX = BASE_IDX + 8'd1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base <= BASE_RST;
      end else if (wr_en) begin
         if (idx == BASE_IDX)
            base[15:8] <= wdata;
         if (idx == BASE_LO_IDX)
            base[7:0] <= wdata;
      end
   end

   generate
      if (NUM_SIMPLE > 0) begin : g_simple
         for (genvar g = 0; g < NUM_SIMPLE; g++) begin : g_grp
            localparam logic [7:0] MY_IDX = SIMPLE_BASE + 8'(g);
            always_ff @(posedge clk) begin
               if (!rst_n)
                  simple_en[g*8 +: 8] <= '0;
               else if (wr_en && idx == MY_IDX)
                  simple_en[g*8 +: 8] <= wdata;
            end
         end
      end else begin : g_no_simple
         assign simple_en = '0;
      end
   endgenerate

   generate
      for (genvar g = 0; g < NUM_OE; g++) begin : g_oe
         localparam logic [7:0] MY_IDX = OE_BASE + 8'(g);
         always_ff @(posedge clk) begin
            if (!rst_n)
               oe[g*8 +: 8] <= '0;
            else if (wr_en && idx == MY_IDX)
               oe[g*8 +: 8] <= wdata;
         end
      end
   endgenerate

   always_comb begin
      rd_val = RD_FLOAT;
      if (idx == BASE_IDX)
         rd_val = base[15:8];
      if (idx == BASE_LO_IDX)
         rd_val = base[7:0];
      for (int g = 0; g < NUM_SIMPLE; g++)
         if (idx == SIMPLE_BASE + 8'(g))
            rd_val = simple_en[g*8 +: 8];
      for (int g = 0; g < NUM_OE; g++)
         if (idx == OE_BASE + 8'(g))
            rd_val = oe[g*8 +: 8];
   end

endmodule

// File: rtl/svio_cfg_port.sv
module svio_cfg_port
   import svio_pkg::*;
#(
   parameter logic [15:0] IDX_PORT    = 16'h002E,
   parameter logic [15:0] DAT_PORT    = 16'h002F,
   parameter logic [15:0] CHIP_ID     = 16'h8728,
   parameter logic [3:0]  CHIP_REV    = 4'h3,
   parameter logic [7:0]  GPIO_LDN    = 8'h07,
   parameter int          NUM_SIMPLE  = 5,
   parameter int          NUM_OE      = 8,
   parameter logic [7:0]  SIMPLE_BASE = 8'hC0,
   parameter logic [7:0]  OE_BASE     = 8'hC8,
   parameter logic [7:0]  BASE_IDX    = 8'h62,
   parameter logic [15:0] BASE_RST    = 16'h0A00,
   localparam int         SIMPLE_W    = (NUM_SIMPLE > 0) ? NUM_SIMPLE * 8 : 8,
   localparam int         OE_W        = NUM_OE * 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [15:0]         bus_addr,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [7:0]          bus_wdata,
   output logic [7:0]          bus_rdata,
   output logic                cfg_open,
   output logic [15:0]         gpio_base,
   output logic [SIMPLE_W-1:0] gpio_simple_en,
   output logic [OE_W-1:0]     gpio_oe
);

   generate
      if (NUM_OE < 1 || NUM_OE > 8) begin : g_bad_oe
         $error("NUM_OE must be 1..8");
      end
      if (NUM_SIMPLE < 0 || NUM_SIMPLE > 8) begin : g_bad_simple
         $error("NUM_SIMPLE must be 0..8");
      end
      if (SIMPLE_BASE < BANK_FIRST || OE_BASE < BANK_FIRST || BASE_IDX < BANK_FIRST) begin : g_bad_bank
         $error("bank registers must sit at or above the bank start");
      end
      if (!((int'(SIMPLE_BASE) + NUM_SIMPLE <= int'(OE_BASE)) ||
            (int'(OE_BASE) + NUM_OE <= int'(SIMPLE_BASE)))) begin : g_bad_overlap
         $error("simple-I/O and output-enable ranges overlap");
      end
      if (int'(OE_BASE) + NUM_OE > 256 || int'(SIMPLE_BASE) + NUM_SIMPLE > 256 ||
          int'(BASE_IDX) > 254) begin : g_bad_top
         $error("bank registers exceed index space");
      end
      if (IDX_PORT == DAT_PORT) begin : g_bad_ports
         $error("index and data ports must differ");
      end
   endgenerate

   logic  hit_idx, hit_dat, idx_wr, dat_wr;
   logic  relock, in_global, bank_wr;
   byte_t cur_idx, cur_ldn, glb_rd, bank_rd;

   assign hit_idx = (bus_addr == IDX_PORT);
   assign hit_dat = (bus_addr == DAT_PORT);
   assign idx_wr  = bus_wr && hit_idx;
   assign dat_wr  = bus_wr && hit_dat;

   svio_key_match #(.LEN(KEY_LEN)) u_key (
      .clk    (clk),
      .rst_n  (rst_n),
      .kick   (idx_wr),
      .kbyte  (bus_wdata),
      .relock (relock),
      .open   (cfg_open)
   );

   svio_global_regs #(.CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV)) u_glb (
      .clk       (clk),
      .rst_n     (rst_n),
      .open      (cfg_open),
      .idx_wr    (idx_wr),
      .dat_wr    (dat_wr),
      .wdata     (bus_wdata),
      .idx       (cur_idx),
      .ldn       (cur_ldn),
      .relock    (relock),
      .in_global (in_global),
      .rd_val    (glb_rd)
   );

   assign bank_wr = cfg_open && dat_wr && !in_global && (cur_ldn == GPIO_LDN);

   svio_gpio_bank #(
      .NUM_SIMPLE  (NUM_SIMPLE),
      .NUM_OE      (NUM_OE),
      .SIMPLE_BASE (SIMPLE_BASE),
      .OE_BASE     (OE_BASE),
      .BASE_IDX    (BASE_IDX),
      .BASE_RST    (BASE_RST)
   ) u_gpio (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bank_wr),
      .idx       (cur_idx),
      .wdata     (bus_wdata),
      .base      (gpio_base),
      .simple_en (gpio_simple_en),
      .oe        (gpio_oe),
      .rd_val    (bank_rd)
   );

   byte_t dat_val;

   always_comb begin
      if (!cfg_open)
         dat_val = RD_FLOAT;
      else if (in_global)
         dat_val = glb_rd;
      else if (cur_ldn == GPIO_LDN)
         dat_val = bank_rd;
      else
         dat_val = RD_FLOAT;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= RD_FLOAT;
      end else if (bus_rd) begin
         if (hit_idx)
            bus_rdata <= cfg_open ? cur_idx : RD_FLOAT;
         else if (hit_dat)
            bus_rdata <= dat_val;
         else
            bus_rdata <= RD_FLOAT;
      end
   end

endmodule

// File: rtl/svio_cfg_port_chk.sv
module svio_cfg_port_chk #(
   parameter logic [15:0] IDX_PORT = 16'h002E,
   parameter logic [15:0] DAT_PORT = 16'h002F,
   parameter logic [15:0] CHIP_ID  = 16'h8728,
   parameter logic [7:0]  GPIO_LDN = 8'h07,
   parameter int          SIMPLE_W = 40,
   parameter int          OE_W     = 64
) (
   input logic                clk,
   input logic                rst_n,
   input logic [15:0]         bus_addr,
   input logic                bus_wr,
   input logic                bus_rd,
   input logic [7:0]          bus_wdata,
   input logic [7:0]          bus_rdata,
   input logic                cfg_open,
   input logic [15:0]         gpio_base,
   input logic [SIMPLE_W-1:0] gpio_simple_en,
   input logic [OE_W-1:0]     gpio_oe,
   input logic [7:0]          cur_idx,
   input logic [7:0]          cur_ldn
);

   AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_open) |-> $past(bus_wr && bus_addr == IDX_PORT && bus_wdata == 8'h55)); // R2

   AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !cfg_open && (bus_addr == DAT_PORT || bus_addr == IDX_PORT)) |=> bus_rdata == 8'hFF); // R4

   AST_LOCKED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !cfg_open && bus_addr == DAT_PORT) |=>
         ($stable(gpio_base) && $stable(gpio_simple_en) && $stable(gpio_oe))); // R4

   AST_ID_HIGH_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && cfg_open && bus_addr == DAT_PORT && cur_idx == 8'h20) |=> bus_rdata == CHIP_ID[15:8]); // R6

   AST_OTHER_LDN_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && cfg_open && bus_addr == DAT_PORT && cur_ldn != GPIO_LDN) |=>
         ($stable(gpio_base) && $stable(gpio_simple_en) && $stable(gpio_oe))); // R7

   AST_EXIT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && cfg_open && bus_addr == DAT_PORT && cur_idx == 8'h02 && bus_wdata == 8'h02) |=> !cfg_open); // R11

   AST_FOREIGN_ADDR_FF: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr != IDX_PORT && bus_addr != DAT_PORT) |=> bus_rdata == 8'hFF); // R12

endmodule

bind svio_cfg_port svio_cfg_port_chk #(
   .IDX_PORT (IDX_PORT),
   .DAT_PORT (DAT_PORT),
   .CHIP_ID  (CHIP_ID),
   .GPIO_LDN (GPIO_LDN),
   .SIMPLE_W (SIMPLE_W),
   .OE_W     (OE_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .bus_addr       (bus_addr),
   .bus_wr         (bus_wr),
   .bus_rd         (bus_rd),
   .bus_wdata      (bus_wdata),
   .bus_rdata      (bus_rdata),
   .cfg_open       (cfg_open),
   .gpio_base      (gpio_base),
   .gpio_simple_en (gpio_simple_en),
   .gpio_oe        (gpio_oe),
   .cur_idx        (cur_idx),
   .cur_ldn        (cur_ldn)
);

// File: tb/sim_svio_cfg_port.sv
module sim_svio_cfg_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = 16'h0000;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = 8'h00;
   logic [7:0]  bus_rdata;
   logic        cfg_open;
   logic [15:0] gpio_base;
   logic [39:0] gpio_simple_en;
   logic [63:0] gpio_oe;

   int    total = 0;
   int    bad = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   svio_cfg_port u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_open(cfg_open),
      .gpio_base(gpio_base), .gpio_simple_en(gpio_simple_en), .gpio_oe(gpio_oe)
   );

   // behavioural reference model
   bit        m_open;
   int        m_kpos;
   int        m_idx, m_ldn, m_base;
   int        m_rd;
   int        m_simple[5];
   int        m_oe[8];
   int        key_q[$] = '{8'h87, 8'h01, 8'h55, 8'h55};

   function automatic int m_value(int ix);
      if (ix == 8'h07) return m_ldn;
      if (ix == 8'h20) return 8'h87;
      if (ix == 8'h21) return 8'h28;
      if (ix == 8'h22) return 8'h03;
      if (ix < 8'h30) return 8'hFF;
      if (m_ldn != 7) return 8'hFF;
      if (ix == 8'h62) return m_base / 256;
      if (ix == 8'h63) return m_base % 256;
      if (ix >= 8'hC0 && ix < 8'hC5) return m_simple[ix - 8'hC0];
      if (ix >= 8'hC8 && ix <= 8'hCF) return m_oe[ix - 8'hC8];
      return 8'hFF;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_open = 0; m_kpos = 0; m_idx = 0; m_ldn = 0; m_base = 16'h0A00; m_rd = 8'hFF;
         foreach (m_simple[i]) m_simple[i] = 0;
         foreach (m_oe[i]) m_oe[i] = 0;
      end else begin
         if (bus_rd) begin
            if (bus_addr == 16'h002E) m_rd = m_open ? m_idx : 8'hFF;
            else if (bus_addr == 16'h002F) m_rd = m_open ? m_value(m_idx) : 8'hFF;
            else m_rd = 8'hFF;
         end
         if (bus_wr && bus_addr == 16'h002E) begin
            if (m_open) m_idx = bus_wdata;
            else if (bus_wdata == key_q[m_kpos]) begin
               if (m_kpos == key_q.size() - 1) begin m_open = 1; m_kpos = 0; end
               else m_kpos++;
            end else m_kpos = (bus_wdata == key_q[0]) ? 1 : 0;
         end
         if (bus_wr && bus_addr == 16'h002F && m_open) begin
            if (m_idx == 2 && bus_wdata == 2) begin m_open = 0; m_kpos = 0; end
            else if (m_idx == 7) m_ldn = bus_wdata;
            else if (m_idx >= 8'h30 && m_ldn == 7) begin
               if (m_idx == 8'h62) m_base = bus_wdata * 256 + m_base % 256;
               if (m_idx == 8'h63) m_base = (m_base / 256) * 256 + bus_wdata;
               if (m_idx >= 8'hC0 && m_idx < 8'hC5) m_simple[m_idx - 8'hC0] = bus_wdata;
               if (m_idx >= 8'hC8 && m_idx <= 8'hCF) m_oe[m_idx - 8'hC8] = bus_wdata;
            end
         end
      end
   end

   task automatic chk(string req, string what, longint act, longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         longint es, eo;
         es = 0; eo = 0;
         for (int i = 0; i < 5; i++) es = es | (longint'(m_simple[i]) << (8 * i));
         for (int i = 0; i < 8; i++) eo = eo | (longint'(m_oe[i]) << (8 * i));
         chk(cur_req, "model open", cfg_open, m_open);
         chk(cur_req, "model rdata", bus_rdata, m_rd);
         chk(cur_req, "model base", gpio_base, m_base);
         chk(cur_req, "model simple", gpio_simple_en, es);
         chk(cur_req, "model oe", gpio_oe, eo);
      end
   end

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic reg_wr(input logic [7:0] ix, input logic [7:0] d);
      wr(16'h002E, ix);
      wr(16'h002F, d);
   endtask

   task automatic reg_rd(input logic [7:0] ix, output logic [7:0] d);
      wr(16'h002E, ix);
      rd(16'h002F, d);
   endtask

   task automatic unlock();
      wr(16'h002E, 8'h87); wr(16'h002E, 8'h01); wr(16'h002E, 8'h55); wr(16'h002E, 8'h55);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      chk("R1", "open after reset", cfg_open, 0);
      chk("R1", "base after reset", gpio_base, 16'h0A00);
      chk("R1", "oe after reset", gpio_oe, 0);
      chk("R1", "rdata after reset", bus_rdata, 8'hFF);

      cur_req = "R4";
      wr(16'h002F, 8'h5A);
      rd(16'h002F, v); chk("R4", "locked data read", v, 8'hFF);
      rd(16'h002E, v); chk("R4", "locked index read", v, 8'hFF);
      chk("R4", "locked write oe", gpio_oe, 0);

      cur_req = "R3";
      wr(16'h002E, 8'h87); wr(16'h002E, 8'h01); wr(16'h002E, 8'h55);
      wr(16'h002E, 8'h00); wr(16'h002E, 8'h55);
      chk("R3", "broken key stays locked", cfg_open, 0);
      wr(16'h002E, 8'h87); wr(16'h002E, 8'h87); wr(16'h002E, 8'h01);
      wr(16'h002E, 8'h55);
      chk("R3", "not open before last byte", cfg_open, 0);
      cur_req = "R2";
      wr(16'h002E, 8'h55);
      chk("R2", "open after key", cfg_open, 1);

      cur_req = "R5";
      wr(16'h002E, 8'h4C);
      rd(16'h002E, v); chk("R5", "index readback", v, 8'h4C);

      cur_req = "R6";
      reg_rd(8'h20, v); chk("R6", "id high", v, 8'h87);
      reg_rd(8'h21, v); chk("R6", "id low", v, 8'h28);
      reg_rd(8'h22, v); chk("R6", "revision", v, 8'h03);
      reg_wr(8'h20, 8'h11);
      reg_rd(8'h20, v); chk("R6", "id write ignored", v, 8'h87);

      cur_req = "R7";
      reg_rd(8'h07, v); chk("R7", "ldn reset", v, 8'h00);
      reg_wr(8'h07, 8'h05);
      reg_rd(8'h07, v); chk("R7", "ldn readback", v, 8'h05);
      reg_wr(8'hC8, 8'hFF);
      chk("R7", "foreign ldn oe", gpio_oe, 0);
      reg_rd(8'h62, v); chk("R7", "foreign ldn read", v, 8'hFF);
      reg_wr(8'h07, 8'h07);

      cur_req = "R8";
      reg_wr(8'h62, 8'h12);
      reg_wr(8'h63, 8'h34);
      chk("R8", "gpio base", gpio_base, 16'h1234);
      reg_rd(8'h62, v); chk("R8", "base high read", v, 8'h12);

      cur_req = "R9";
      reg_wr(8'hC0, 8'hA5);
      reg_wr(8'hC4, 8'h3C);
      chk("R9", "simple group 0", gpio_simple_en[7:0], 8'hA5);
      chk("R9", "simple group 4", gpio_simple_en[39:32], 8'h3C);
      reg_rd(8'hC5, v); chk("R9", "past last simple group", v, 8'hFF);

      cur_req = "R10";
      reg_wr(8'hC8, 8'h0F);
      reg_wr(8'hCF, 8'h80);
      chk("R10", "oe groups", gpio_oe, 64'h8000_0000_0000_000F);
      reg_rd(8'hCF, v); chk("R10", "oe group 7 read", v, 8'h80);

      cur_req = "R12";
      rd(16'h0080, v); chk("R12", "foreign address", v, 8'hFF);
      reg_rd(8'h90, v); chk("R12", "unimplemented index", v, 8'hFF);

      cur_req = "R11";
      reg_wr(8'h02, 8'h01);
      chk("R11", "wrong exit value", cfg_open, 1);
      reg_wr(8'h02, 8'h02);
      chk("R11", "exit locks", cfg_open, 0);
      rd(16'h002F, v); chk("R11", "read after exit", v, 8'hFF);
      unlock();
      chk("R2", "reopen", cfg_open, 1);
      reg_rd(8'hC8, v); chk("R10", "oe kept over lock", v, 8'h0F);

      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule